// File: doc/BRIEF.md
# Synchronized Multi-Channel Counter Group

The block holds six 16-bit up-counters behind one small register port. Each counter counts up when its own count-enable input is high. Software writes the counter directly to load it. A channel can be cleared by its own clear input.

A shared grouping register holds one enable bit per channel. Channels whose bit is set form a single group, and the group takes effect only when at least two bits are set. A bus write to a grouped counter loads the same value into every group member in the same cycle. When a group member's own clear fires, every group member whose clear-select field asks for group clearing is also zeroed in that cycle. Channels outside the group run on their own.

Each channel's clear-select field decodes into one of three clear modes: OFF (never cleared), OWN (cleared by its own clear input) and GROUP (cleared when any group member clears). These are the per-channel states. A channel moves between them only by a bus write to its select field. Each counter cycle is resolved in a fixed order: a clear takes priority over a load, and a load takes priority over an increment.

Top module: `sync_counter_group`

## Requirements
- R1: After reset, every counter, every clear-select field and the grouping register read back as 0.
- R2: The grouping register is at address 12, with channel i at bit i for bits 0 to 5. A read returns 0 in bits 15 to 6 whatever was written.
- R3: Counter i is at address i (0 to 5) and reads back its live value. It increases by one on each cycle its count enable is high, and wraps from 0xFFFF to 0x0000.
- R4: A write to a counter whose grouping bit is 0 loads only that counter.
- R5: When two or more grouping bits are set, a write to any member counter loads the written value into every member in the same cycle. Non-members are unchanged.
- R6: When exactly one grouping bit is set, that channel behaves as an independent channel. Its writes load only itself, and no other channel's clear reaches it.
- R7: The clear-select field of channel i is at address 6+i and reads back its 3 stored bits. 000 means OFF, 001 means OWN and 011 means GROUP. Every other code acts as OFF.
- R8: A channel in OWN mode is zeroed in the cycle after its clear input is high.
- R9: When an active-group member in OWN mode sees its clear input, every active-group member in GROUP mode is zeroed in the same cycle. Members in OFF mode and non-members keep their value.
- R10: When a clear and a load reach the same counter in the same cycle, the counter becomes 0.
- R11: A load in a cycle with count enable high stores exactly the written value, with no increment in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr`, combinational |
| cnt_en | input | 6 | Per-channel count enable |
| clr_in | input | 6 | Per-channel clear event |

## Verification
The preset fan-out is swept over all 64 grouping masks, with a write to each of the six channels in turn. Each channel is first given its own background value. This separates the no-group, single-bit and active-group cases and shows exactly which channels a write reaches. The clear fan-out is swept the same way, with a fixed mix of OWN, GROUP, OFF and undefined select codes. This separates a channel's own clear, a group-propagated clear and clear codes that must be ignored. Directed cases then cover wrap-around, a load together with count enable, and a clear together with a load in both the independent and the grouped case.

// File: rtl/scg_pkg.sv
package scg_pkg;

    typedef enum logic [1:0] {
        CLR_OFF  = 2'd0,
        CLR_OWN  = 2'd1,
        CLR_SYNC = 2'd2
    } clr_mode_e;

    localparam int SEL_W = 3;

    function automatic clr_mode_e decode_sel(input logic [SEL_W-1:0] code);
        clr_mode_e m;
        case (code)
            3'b001:  m = CLR_OWN;
            3'b011:  m = CLR_SYNC;
            default: m = CLR_OFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/scg_regs.sv
module scg_regs
    import scg_pkg::*;
#(
    parameter int NUM_CH    = 6,
    parameter int ADDR_W    = 4,
    parameter int SEL_BASE  = 6,
    parameter int SYNC_ADDR = 12,
    localparam int REG_W    = (NUM_CH > SEL_W) ? NUM_CH : SEL_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [REG_W-1:0]              wr_bits,
    output logic [NUM_CH-1:0]             sync_q,
    output logic [NUM_CH-1:0][SEL_W-1:0]  sel_q,
    output clr_mode_e [NUM_CH-1:0]        mode,
    output logic [NUM_CH-1:0]             member
);

    logic group_on;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else if (wr_en && addr == ADDR_W'(SYNC_ADDR)) begin
            sync_q <= wr_bits[NUM_CH-1:0];
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sel_q[i] <= '0;
            end else if (wr_en && addr == ADDR_W'(SEL_BASE + i)) begin
                sel_q[i] <= wr_bits[SEL_W-1:0];
            end
        end

        always_comb begin
            mode[i] = decode_sel(sel_q[i]);
        end
    end

    always_comb begin
        int n;
        n = 0;
        for (int i = 0; i < NUM_CH; i++) begin
            n = n + int'(sync_q[i]);
        end
        group_on = (n >= 2);
        member   = group_on ? sync_q : '0;
    end

    // R6
    single_member_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(member) != 1);

    // R1
    reset_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sync_q == '0));

endmodule

// File: rtl/scg_fanout.sv
module scg_fanout
    import scg_pkg::*;
#(
    parameter int NUM_CH   = 6,
    parameter int ADDR_W   = 4,
    parameter int CNT_BASE = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [NUM_CH-1:0]       member,
    input  clr_mode_e [NUM_CH-1:0]  mode,
    input  logic [NUM_CH-1:0]       clr_in,
    output logic [NUM_CH-1:0]       ld_vec,
    output logic [NUM_CH-1:0]       clr_vec
);

    logic [NUM_CH-1:0] wr_hit;
    logic [NUM_CH-1:0] own_clr;
    logic [NUM_CH-1:0] want_sync;
    logic              grp_load;
    logic              grp_clear;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        always_comb begin
            wr_hit[i]    = wr_en && (addr == ADDR_W'(CNT_BASE + i));
            own_clr[i]   = (mode[i] == CLR_OWN) && clr_in[i];
            want_sync[i] = (mode[i] == CLR_SYNC) && member[i];
        end
    end

    always_comb begin
        grp_load  = |(wr_hit & member);
        grp_clear = |(own_clr & member);
        ld_vec    = wr_hit | (grp_load ? member : '0);
        clr_vec   = own_clr | (grp_clear ? want_sync : '0);
    end

    // R4
    indep_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (member == '0) |-> $onehot0(ld_vec));

    // R9
    nonmember_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_vec & ~member & ~clr_in) == '0));

    // R5
    group_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ld_vec & member) != '0) |-> ((ld_vec & member) == member));

endmodule

// File: rtl/scg_channel.sv
module scg_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             load,
    input  logic             clear,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (load) begin
            count <= ld_val;
        end else if (cnt_en) begin
            count <= count + CNT_W'(1);
        end
    end

    // R10
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0));

    // R11
    load_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clear) |=> (count == $past(ld_val)));

    // R3
    increment_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !load && !clear) |=> (count == $past(count) + CNT_W'(1)));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !load && !clear) |=> $stable(count));

endmodule

// File: rtl/sync_counter_group.sv
module sync_counter_group
    import scg_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  rd_data,
    input  logic [NUM_CH-1:0] cnt_en,
    input  logic [NUM_CH-1:0] clr_in
);

    localparam int CNT_BASE  = 0;
    localparam int SEL_BASE  = CNT_BASE + NUM_CH;
    localparam int SYNC_ADDR = SEL_BASE + NUM_CH;
    localparam int REG_W     = (NUM_CH > SEL_W) ? NUM_CH : SEL_W;

    logic [NUM_CH-1:0]             sync_q;
    logic [NUM_CH-1:0][SEL_W-1:0]  sel_q;
    clr_mode_e [NUM_CH-1:0]        mode;
    logic [NUM_CH-1:0]             member;
    logic [NUM_CH-1:0]             ld_vec;
    logic [NUM_CH-1:0]             clr_vec;
    logic [NUM_CH-1:0][CNT_W-1:0]  count;

    scg_regs #(
        .NUM_CH    (NUM_CH),
        .ADDR_W    (ADDR_W),
        .SEL_BASE  (SEL_BASE),
        .SYNC_ADDR (SYNC_ADDR)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_bits (wr_data[REG_W-1:0]),
        .sync_q  (sync_q),
        .sel_q   (sel_q),
        .mode    (mode),
        .member  (member)
    );

    scg_fanout #(
        .NUM_CH   (NUM_CH),
        .ADDR_W   (ADDR_W),
        .CNT_BASE (CNT_BASE)
    ) u_fanout (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .member  (member),
        .mode    (mode),
        .clr_in  (clr_in),
        .ld_vec  (ld_vec),
        .clr_vec (clr_vec)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        scg_channel #(
            .CNT_W (CNT_W)
        ) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .cnt_en (cnt_en[i]),
            .load   (ld_vec[i]),
            .clear  (clr_vec[i]),
            .ld_val (wr_data),
            .count  (count[i])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(CNT_BASE + i)) rd_data = count[i];
            if (addr == ADDR_W'(SEL_BASE + i)) rd_data = CNT_W'(sel_q[i]);
        end
        if (addr == ADDR_W'(SYNC_ADDR)) rd_data = CNT_W'(sync_q);
    end

    // R2
    sync_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(SYNC_ADDR)) |-> (rd_data[CNT_W-1:NUM_CH] == '0));

    // R7
    sel_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= ADDR_W'(SEL_BASE) && addr < ADDR_W'(SYNC_ADDR))
            |-> (rd_data[CNT_W-1:SEL_W] == '0));

endmodule

// File: tb/sync_counter_group_bench.sv
module sync_counter_group_bench;

    localparam int N    = 6;
    localparam int SYNC = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [5:0]  cnt_en = '0;
    logic [5:0]  clr_in = '0;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    sync_counter_group u_sync_counter_group (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .cnt_en  (cnt_en),
        .clr_in  (clr_in)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, input string req, input logic [15:0] exp);
        addr = 4'(a);
        #1;
        chk(req, rd_data, exp);
    endtask

    function automatic int popc(input logic [5:0] m);
        int n = 0;
        for (int i = 0; i < N; i++) n += int'(m[i]);
        return n;
    endfunction

    function automatic bit is_mem(input logic [5:0] m, input int i);
        return (popc(m) >= 2) && m[i];
    endfunction

    // clear-select codes used in the clear sweep
    function automatic logic [2:0] sel_of(input int i);
        case (i)
            0: return 3'b001;
            1: return 3'b011;
            2: return 3'b011;
            3: return 3'b000;
            4: return 3'b001;
            default: return 3'b111;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state of every register
        for (int a = 0; a <= SYNC; a++) rd(a, "R1", 16'h0000);

        // R2 reserved sync bits
        wr(SYNC, 16'hFFFF);
        rd(SYNC, "R2", 16'h003F);
        wr(SYNC, 16'h0000);
        rd(SYNC, "R2", 16'h0000);

        // R7 select field width
        wr(8, 16'hFFFF);
        rd(8, "R7", 16'h0007);
        wr(8, 16'h0000);

        // R3 counting and wrap
        wr(3, 16'hFFFE);
        @(negedge clk); cnt_en = 6'b001000;
        repeat (3) @(negedge clk);
        cnt_en = '0;
        rd(3, "R3", 16'h0001);

        // R11 load with count enable high
        @(negedge clk);
        cnt_en = 6'b000100; wr_en = 1'b1; addr = 4'd2; wr_data = 16'h1234;
        @(negedge clk);
        wr_en = 1'b0;
        rd(2, "R11", 16'h1234);
        @(negedge clk);
        cnt_en = '0;
        rd(2, "R3", 16'h1235);

        // preset sweep: R4, R5, R6
        for (int m = 0; m < 64; m++) begin
            for (int k = 0; k < N; k++) begin
                logic [15:0] v;
                string tag;
                v = 16'hA000 | 16'(m << 4) | 16'(k);
                wr(SYNC, 16'h0000);
                for (int i = 0; i < N; i++) wr(i, 16'h0100 * 16'(i + 1));
                wr(SYNC, 16'(m));
                wr(k, v);
                if (popc(6'(m)) >= 2 && m[k]) tag = "R5";
                else if (popc(6'(m)) == 1) tag = "R6";
                else tag = "R4";
                for (int i = 0; i < N; i++) begin
                    logic [15:0] e;
                    e = (i == k || (is_mem(6'(m), i) && is_mem(6'(m), k)))
                        ? v : 16'h0100 * 16'(i + 1);
                    rd(i, tag, e);
                end
            end
        end

        // clear sweep: R7, R8, R9
        for (int i = 0; i < N; i++) wr(6 + i, 16'(sel_of(i)));
        for (int i = 0; i < N; i++) rd(6 + i, "R7", 16'(sel_of(i)));
        for (int m = 0; m < 64; m++) begin
            for (int k = 0; k < N; k++) begin
                wr(SYNC, 16'h0000);
                for (int i = 0; i < N; i++) wr(i, 16'h0A00 + 16'(i));
                wr(SYNC, 16'(m));
                @(negedge clk); clr_in = 6'(1 << k);
                @(negedge clk); clr_in = '0;
                for (int i = 0; i < N; i++) begin
                    bit src, cl;
                    string tag;
                    src = (sel_of(k) == 3'b001);
                    cl  = (i == k && src) ||
                          (src && is_mem(6'(m), k) && is_mem(6'(m), i)
                           && sel_of(i) == 3'b011);
                    if (k == 5 || sel_of(k) != 3'b001) tag = "R7";
                    else if (i == k) tag = "R8";
                    else if (popc(6'(m)) == 1) tag = "R6";
                    else tag = "R9";
                    rd(i, tag, cl ? 16'h0000 : 16'h0A00 + 16'(i));
                end
            end
        end

        // R10 clear versus load, independent channel 0
        wr(SYNC, 16'h0000);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'd0; wr_data = 16'h5555; clr_in = 6'b000001;
        @(negedge clk);
        wr_en = 1'b0; clr_in = '0;
        rd(0, "R10", 16'h0000);

        // R10 grouped: members 0..3, write ch3, ch0 clears
        for (int i = 0; i < N; i++) wr(i, 16'h0B00 + 16'(i));
        wr(SYNC, 16'h000F);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'd3; wr_data = 16'h7777; clr_in = 6'b000001;
        @(negedge clk);
        wr_en = 1'b0; clr_in = '0;
        rd(0, "R10", 16'h0000);
        rd(1, "R10", 16'h0000);
        rd(2, "R10", 16'h0000);
        rd(3, "R10", 16'h7777);
        rd(4, "R5", 16'h0B04);
        rd(5, "R5", 16'h0B05);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule